// File: doc/BRIEF.md
# SIMT Lane Iteration and Predication Sequencer

This block lets a small set of physical integer lanes carry a larger thread group in lock-step. The thread group holds `LANES * ITERS` threads. Each instruction accepted on the issue handshake is replayed `ITERS` times in consecutive cycles, one pass per cycle. In pass `p`, lane `l` works for thread `p*LANES + l`. For every pass the block tells each lane which per-thread register bank to use, and it gates that lane's register write and memory request.

Divergence is handled by masking lanes instead of branching. Each thread has an annul bit. A conditional-branch instruction tests each thread's own condition flags. A thread whose condition holds skips the body of the if-region: its bit is set, and its later writes and memory requests are suppressed. An end-of-region instruction returns all threads to active. Only if-without-else regions are supported, so there is no inversion of the mask. Decode, the ALU datapath and memory access belong to neighbouring blocks.

Top module: `simt_lane_iter`

## Requirements
- R1: After reset the block shows `in_ready=1` and `pass_valid=0`, and drives all lane outputs to 0. Every thread is active, with no annul bits set.
- R2: An instruction is taken when `in_valid && in_ready` at a clock edge. Its passes appear in the following `ITERS` cycles with `pass_idx` = 0, 1, ... `ITERS-1`. `pass_last` is high only on the final pass.
- R3: `in_ready` is low during every pass except the last. It is high when the block is idle or on the last pass, so a new instruction can follow with no idle cycle.
- R4: During pass `p`, the field `lane_bank[l*TW +: TW]` equals `p*LANES + l`. This is the register bank index of the thread served by lane `l`.
- R5: During a pass, `lane_live[l]` is 1 exactly when the thread served by lane `l` is not annulled. `lane_wr[l] = wr & lane_live[l]` and `lane_mem[l] = mem & lane_live[l]`, where `wr` and `mem` are the write and memory flags latched with the instruction.
- R6: On each pass of a conditional-branch instruction, the annul bit of the thread on lane `l` is set when its condition is true on `lane_cc[l*4 +: 4]`. The flag bits are {N,Z,V,C} from bit 3 down to bit 0. Annul bits are sticky (OR). They take effect from the next instruction, and the branch itself runs with the old mask. The encodings of `in_cond` are: 0 never, 1 always, 2 Z, 3 !Z, 4 N^V, 5 !(N^V), 6 C, 7 N.
- R7: An end-of-region instruction runs its passes with the current mask. After its last pass, all annul bits are cleared. When the same instruction is also a branch, the clear wins.
- R8: An instruction whose threads are all annulled still occupies all `ITERS` passes.
- R9: Outside passes, all lane outputs are 0. `lane_cc` has no effect on the annul state except on passes of a branch instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_wr | input | 1 | Instruction writes a register |
| in_mem | input | 1 | Instruction issues a memory request |
| in_branch | input | 1 | Conditional branch: updates annul bits |
| in_cond | input | 3 | Condition select for a branch |
| in_rejoin | input | 1 | End of if-region: restore all-active |
| lane_cc | input | LANES*4 | Per-lane {N,Z,V,C} flags of the current pass |
| pass_valid | output | 1 | A pass is running this cycle |
| pass_idx | output | PW | Index of the current pass |
| pass_last | output | 1 | Current pass is the final one |
| lane_bank | output | LANES*TW | Per-lane thread register bank index |
| lane_live | output | LANES | Lane's thread is not annulled |
| lane_wr | output | LANES | Per-lane register write enable |
| lane_mem | output | LANES | Per-lane memory request |

## Verification
The hardest state to reach is a mask that differs from pass to pass and builds up across several branches. Only such a mask shows whether a thread's bit is indexed by both lane and pass. The stimulus chains random branches with random flags and random conditions, and inserts end-of-region instructions only occasionally. Many different partial masks therefore build up before each clear. Directed cases cover an all-annulled instruction, a branch that is also an end-of-region, and back-to-back issue on the last pass.

// File: rtl/simt_lane_pkg.sv
package simt_lane_pkg;

   typedef struct packed {
      logic       wr;
      logic       mem;
      logic       branch;
      logic       rejoin;
      logic [2:0] cond;
   } simt_op_t;

   // flags: [3]=N [2]=Z [1]=V [0]=C
   function automatic logic cond_hit(input logic [2:0] sel, input logic [3:0] f);
      logic r;
      case (sel)
         3'd0:    r = 1'b0;
         3'd1:    r = 1'b1;
         3'd2:    r = f[2];
         3'd3:    r = ~f[2];
         3'd4:    r = f[3] ^ f[1];
         3'd5:    r = ~(f[3] ^ f[1]);
         3'd6:    r = f[0];
         default: r = f[3];
      endcase
      return r;
   endfunction

endpackage

// File: rtl/simt_pass_seq.sv
module simt_pass_seq #(
   parameter int ITERS = 2,
   parameter int PW    = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   output logic          take,
   output logic          pass_valid,
   output logic [PW-1:0] pass_idx,
   output logic          pass_last
);
   logic run_q;

   assign take       = in_valid & in_ready;
   assign pass_valid = run_q;

   generate
      if (ITERS == 1) begin : g_single
         assign pass_idx  = '0;
         assign pass_last = run_q;
         assign in_ready  = 1'b1;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) run_q <= 1'b0;
            else        run_q <= take;
         end
      end else begin : g_multi
         localparam logic [PW-1:0] LAST = PW'(ITERS - 1);
         logic [PW-1:0] cnt_q;
         assign pass_idx  = cnt_q;
         assign pass_last = run_q && (cnt_q == LAST);
         assign in_ready  = !run_q || (cnt_q == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= 1'b0;
               cnt_q <= '0;
            end else if (take) begin
               run_q <= 1'b1;
               cnt_q <= '0;
            end else if (run_q && cnt_q == LAST) begin
               run_q <= 1'b0;
               cnt_q <= '0;
            end else if (run_q) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         a_r2_pass_step: assert property (@(posedge clk) disable iff (!rst_n)
            run_q && !pass_last |=> run_q && (cnt_q == $past(cnt_q) + 1'b1));
      end
   endgenerate

   a_r3_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
      pass_valid && !pass_last |-> !in_ready);
   a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> pass_valid && pass_idx == '0);

endmodule

// File: rtl/simt_pred_mask.sv
module simt_pred_mask
   import simt_lane_pkg::*;
#(
   parameter int LANES = 4,
   parameter int ITERS = 2,
   parameter int PW    = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pass_valid,
   input  logic [PW-1:0]          pass_idx,
   input  logic                   pass_last,
   input  logic                   do_branch,
   input  logic                   do_rejoin,
   input  logic [2:0]             cond,
   input  logic [LANES*4-1:0]     lane_cc,
   output logic [LANES*ITERS-1:0] annul
);
   localparam int THREADS = LANES * ITERS;

   logic [THREADS-1:0] annul_q;
   logic               clear;

   assign clear = pass_valid && pass_last && do_rejoin;
   assign annul = annul_q;

   for (genvar t = 0; t < THREADS; t++) begin : g_thr
      localparam int LN = t % LANES;
      localparam int PS = t / LANES;
      logic hit;
      assign hit = pass_valid && do_branch && (int'(pass_idx) == PS)
                   && cond_hit(cond, lane_cc[LN*4 +: 4]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     annul_q[t] <= 1'b0;
         else if (clear) annul_q[t] <= 1'b0;
         else if (hit)   annul_q[t] <= 1'b1;
      end
   end

   a_r7_rejoin_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear) |-> annul_q == '0);
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (annul_q & $past(annul_q)) == $past(annul_q));
   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass_valid && do_branch) && !clear |=> $stable(annul_q));

endmodule

// File: rtl/simt_lane_gate.sv
module simt_lane_gate #(
   parameter int LANES = 4,
   parameter int ITERS = 2,
   parameter int PW    = 1,
   parameter int TW    = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pass_valid,
   input  logic [PW-1:0]          pass_idx,
   input  logic                   op_wr,
   input  logic                   op_mem,
   input  logic [LANES*ITERS-1:0] annul,
   output logic [LANES*TW-1:0]    lane_bank,
   output logic [LANES-1:0]       lane_live,
   output logic [LANES-1:0]       lane_wr,
   output logic [LANES-1:0]       lane_mem
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [TW-1:0] tid;
      assign tid = TW'(int'(pass_idx) * LANES + l);
      assign lane_bank[l*TW +: TW] = pass_valid ? tid : '0;
      assign lane_live[l] = pass_valid && !annul[tid];
      assign lane_wr[l]   = op_wr  && lane_live[l];
      assign lane_mem[l]  = op_mem && lane_live[l];
   end

   a_r5_wr_needs_live: assert property (@(posedge clk) disable iff (!rst_n)
      ((lane_wr | lane_mem) & ~lane_live) == '0);
   a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !pass_valid |-> (lane_live == '0) && (lane_bank == '0));

endmodule

// File: rtl/simt_lane_iter.sv
module simt_lane_iter
   import simt_lane_pkg::*;
#(
   parameter int LANES = 4,
   parameter int ITERS = 2,
   parameter int PW    = (ITERS > 1) ? $clog2(ITERS) : 1,
   parameter int TW    = (LANES * ITERS > 1) ? $clog2(LANES * ITERS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic                in_wr,
   input  logic                in_mem,
   input  logic                in_branch,
   input  logic [2:0]          in_cond,
   input  logic                in_rejoin,
   input  logic [LANES*4-1:0]  lane_cc,
   output logic                pass_valid,
   output logic [PW-1:0]       pass_idx,
   output logic                pass_last,
   output logic [LANES*TW-1:0] lane_bank,
   output logic [LANES-1:0]    lane_live,
   output logic [LANES-1:0]    lane_wr,
   output logic [LANES-1:0]    lane_mem
);
   generate
      if (LANES < 1 || ITERS < 1) begin : g_bad_size
         $error("simt_lane_iter: LANES and ITERS must be at least 1");
      end
      if ((1 << TW) < LANES * ITERS) begin : g_bad_tw
         $error("simt_lane_iter: TW too narrow for thread count");
      end
      if ((1 << PW) < ITERS) begin : g_bad_pw
         $error("simt_lane_iter: PW too narrow for pass count");
      end
   endgenerate

   logic                   take;
   simt_op_t               op_q;
   logic [LANES*ITERS-1:0] annul;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) op_q <= '0;
      else if (take)
         op_q <= '{wr: in_wr, mem: in_mem, branch: in_branch,
                   rejoin: in_rejoin, cond: in_cond};
   end

   simt_pass_seq #(.ITERS(ITERS), .PW(PW)) u_seq (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .take(take), .pass_valid(pass_valid), .pass_idx(pass_idx),
      .pass_last(pass_last)
   );

   simt_pred_mask #(.LANES(LANES), .ITERS(ITERS), .PW(PW)) u_mask (
      .clk(clk), .rst_n(rst_n), .pass_valid(pass_valid), .pass_idx(pass_idx),
      .pass_last(pass_last), .do_branch(op_q.branch), .do_rejoin(op_q.rejoin),
      .cond(op_q.cond), .lane_cc(lane_cc), .annul(annul)
   );

   simt_lane_gate #(.LANES(LANES), .ITERS(ITERS), .PW(PW), .TW(TW)) u_gate (
      .clk(clk), .rst_n(rst_n), .pass_valid(pass_valid), .pass_idx(pass_idx),
      .op_wr(op_q.wr), .op_mem(op_q.mem), .annul(annul),
      .lane_bank(lane_bank), .lane_live(lane_live), .lane_wr(lane_wr),
      .lane_mem(lane_mem)
   );

   a_r8_full_passes: assert property (@(posedge clk) disable iff (!rst_n)
      pass_valid && !pass_last |=> pass_valid);

endmodule

// File: tb/simt_lane_iter_tb.sv
module simt_lane_iter_tb;
   localparam int LANES = 4;
   localparam int ITERS = 2;
   localparam int PW    = 1;
   localparam int TW    = 3;
   localparam int T     = LANES * ITERS;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 0, rst_n = 0;
   logic in_valid = 0, in_wr = 0, in_mem = 0, in_branch = 0, in_rejoin = 0;
   logic [2:0] in_cond = 0;
   logic [LANES*4-1:0] lane_cc = 0;
   logic in_ready, pass_valid, pass_last;
   logic [PW-1:0] pass_idx;
   logic [LANES*TW-1:0] lane_bank;
   logic [LANES-1:0] lane_live, lane_wr, lane_mem;

   int checks = 0, bad = 0;
   bit done = 0;
   bit [T-1:0] m_annul = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   simt_lane_iter #(.LANES(LANES), .ITERS(ITERS), .PW(PW), .TW(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_wr(in_wr), .in_mem(in_mem), .in_branch(in_branch), .in_cond(in_cond),
      .in_rejoin(in_rejoin), .lane_cc(lane_cc), .pass_valid(pass_valid),
      .pass_idx(pass_idx), .pass_last(pass_last), .lane_bank(lane_bank),
      .lane_live(lane_live), .lane_wr(lane_wr), .lane_mem(lane_mem)
   );

   function automatic bit ref_cond(input logic [2:0] s, input logic [3:0] f);
      case (s)
         0: return 0;
         1: return 1;
         2: return f[2];
         3: return !f[2];
         4: return f[3] ^ f[1];
         5: return !(f[3] ^ f[1]);
         6: return f[0];
         default: return f[3];
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Issue at the current negedge (design idle or on last pass), then walk
   // every pass. Returns positioned at the negedge of the last pass.
   task automatic do_instr(input bit wr, input bit mem, input bit br,
                           input logic [2:0] cond, input bit rj,
                           input logic [ITERS*LANES*4-1:0] cc);
      logic [LANES-1:0] ex_live;
      logic [LANES*TW-1:0] ex_bank;
      bit [T-1:0] nxt;
      chk(in_ready === 1'b1, "R3 ready before issue", in_ready, 1);
      in_valid = 1; in_wr = wr; in_mem = mem; in_branch = br;
      in_cond = cond; in_rejoin = rj;
      @(posedge clk); @(negedge clk);
      in_valid = 0; in_wr = 0; in_mem = 0; in_branch = 0; in_rejoin = 0;
      nxt = m_annul;
      for (int p = 0; p < ITERS; p++) begin
         if (p > 0) @(negedge clk);
         lane_cc = cc[p*LANES*4 +: LANES*4];
         for (int l = 0; l < LANES; l++) begin
            ex_live[l] = !m_annul[p*LANES+l];
            ex_bank[l*TW +: TW] = TW'(p*LANES + l);
            if (br && ref_cond(cond, lane_cc[l*4 +: 4])) nxt[p*LANES+l] = 1;
         end
         chk(pass_valid === 1'b1 && pass_idx === PW'(p), "R2 pass index",
             {pass_valid, 7'(pass_idx)}, {1'b1, 7'(p)});
         chk(pass_last === (p == ITERS-1), "R2 pass_last", pass_last, p == ITERS-1);
         chk(in_ready === (p == ITERS-1), "R3 ready per pass", in_ready, p == ITERS-1);
         chk(lane_bank === ex_bank, "R4 bank select", lane_bank, ex_bank);
         chk(lane_live === ex_live, "R5 live mask", lane_live, ex_live);
         chk(lane_wr === (wr ? ex_live : '0), "R5 write gate", lane_wr, wr ? ex_live : '0);
         chk(lane_mem === (mem ? ex_live : '0), "R5 mem gate", lane_mem, mem ? ex_live : '0);
      end
      m_annul = rj ? '0 : nxt;
   endtask

   task automatic idle_check(input string req);
      @(negedge clk);
      lane_cc = $urandom;
      chk(pass_valid === 0 && lane_live === 0 && lane_wr === 0 && lane_mem === 0,
          req, {pass_valid, lane_live, lane_wr, lane_mem}, 0);
      chk(in_ready === 1, req, in_ready, 1);
   endtask

   initial begin
      logic [ITERS*LANES*4-1:0] cc;
      int dummy;
      dummy = $urandom(32'h1dea5);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(in_ready === 1 && pass_valid === 0 && lane_wr === 0 && lane_mem === 0
          && lane_live === 0, "R1 reset state",
          {in_ready, pass_valid, lane_wr, lane_mem, lane_live}, 32'h1 << (3*LANES+1));
      rst_n = 1;
      @(negedge clk);
      // R1: all threads active after reset
      do_instr(1, 1, 0, 0, 0, '0);
      idle_check("R9 idle outputs zero");
      idle_check("R9 cc ignored while idle");
      // R6: branch with Z set on thread 1 and 6 only, cond Z
      cc = '0;
      cc[1*4+2] = 1; cc[(LANES+2)*4+2] = 1;
      do_instr(0, 0, 1, 3'd2, 0, cc);
      // non-branch with random cc must not change mask (R9)
      do_instr(1, 0, 0, 3'd1, 0, {ITERS*LANES{4'hF}});
      // R6 cond never: no new annul
      do_instr(0, 0, 1, 3'd0, 0, {ITERS*LANES{4'hF}});
      do_instr(1, 1, 0, 0, 0, '0);
      // R7: rejoin runs with old mask then clears
      do_instr(1, 0, 0, 0, 1, '0);
      do_instr(1, 1, 0, 0, 0, '0);
      // R8: annul every thread, then a write instruction still takes all passes
      do_instr(0, 0, 1, 3'd1, 0, '0);
      do_instr(1, 1, 0, 0, 0, '0);
      do_instr(1, 1, 0, 0, 0, '0);
      idle_check("R8 returns idle after full annulled passes");
      // R7: branch + rejoin in one instruction: clear wins
      do_instr(0, 0, 1, 3'd1, 1, '0);
      do_instr(1, 0, 0, 0, 0, '0);
      // random mix, with and without gaps
      for (int n = 0; n < 400; n++) begin
         bit br, rj;
         br = ($urandom % 3) == 0;
         rj = ($urandom % 7) == 0;
         for (int k = 0; k < ITERS*LANES; k++) cc[k*4 +: 4] = 4'($urandom);
         do_instr(1'($urandom), 1'($urandom), br, 3'($urandom), rj, cc);
         if (($urandom % 4) == 0) idle_check("R9 gap idle");
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule